// File: doc/BRIEF.md
# Reference clock loss detector

This block watches a reference clock from the domain of a free-running local oscillator. It raises a flag when the reference stops toggling. A divided copy of the reference and the raw reference each pass through a two-flop synchronizer clocked by the oscillator, followed by a rising-edge detector. A saturating counter counts oscillator cycles since the most recent detected rising edge. When the count reaches a parameterised threshold, the registered loss flag goes high. A rising edge of the raw reference, or of the divided reference, restarts the counter and drops the flag.

Detection can be switched off. While scan mode is high or the detector enable is low, the counter is held at zero and the flag is held low. When detection resumes, counting starts again from zero. Every register in the block is clocked by the oscillator and cleared by an asynchronous active-low reset.

Top module: `clkloss_monitor`

## Requirements
- R1: While the asynchronous reset input is low, the loss flag is low. The counter, synchronizer and edge-detect registers are cleared at the same time, so no rising edge is seen as the reset releases.
- R2: A rising level on the divided reference input that is held steady before oscillator edge a restarts the count at zero on edge a+2. Three register stages lie on that path: two synchronizer flops, then the counter.
- R3: Divided-reference rising edges that arrive at most THRESH oscillator cycles apart keep the loss flag low at all times. The default THRESH is 64.
- R4: With the divided reference held steady after a rising level applied before edge a, the flag is still low after edge a+THRESH+1 and is high after edge a+THRESH+2. That is the edge on which the count reaches THRESH.
- R5: While the flag is high, a rising level on the raw reference applied before edge a leaves the flag high after edge a+1. The flag is low after edge a+2, and the count restarts at zero on that edge.
- R6: Scan mode high or detector enable low, sampled on an oscillator edge, makes the flag low after that edge and holds the count at zero. After detection resumes, the flag is first high THRESH edges later.
- R7: The counter saturates at THRESH, so with no reference edges the flag stays high indefinitely.
- R8: Falling levels on either reference input have no effect. They neither restart the count nor clear the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running local oscillator clock; clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div_i | input | 1 | Divided reference clock, asynchronous to osc_clk |
| ref_raw_i | input | 1 | Raw reference clock, asynchronous to osc_clk |
| scan_en_i | input | 1 | Scan mode; high suppresses detection |
| det_en_i | input | 1 | Detector enable; low suppresses detection |
| loss_o | output | 1 | Registered reference-loss flag |

## Verification
A reference input change applied before oscillator edge a reaches the counter on edge a+2. The flag therefore appears THRESH+2 edges after a divided-reference rise and drops two edges after a raw-reference rise. Suppression by scan mode or the enable takes effect on the very next edge. The bench drives every input on the falling clock edge and checks the flag on the following falling edge. Its directed checks count falling edges exactly, to sample one edge before and one edge after each expected transition. A behavioural model keeps a three-deep history of each reference input and compares the flag on every cycle, including during periodic and random reference patterns.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;
    // Default number of oscillator cycles without a reference edge before loss
    localparam int unsigned DEF_THRESH = 64;
    // Default synchronizer depth (flops in series)
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Width of a counter that must hold values 0..limit
    function automatic int unsigned cnt_width(input int unsigned limit);
        int unsigned w;
        w = 1;
        while ((1 << w) <= limit) w++;
        return w;
    endfunction
endpackage

// File: rtl/clkloss_sync_edge.sv
module clkloss_sync_edge #(
    parameter int unsigned STAGES = clkloss_pkg::DEF_SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } state_t;

    state_t st_d, st_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("clkloss_sync_edge: STAGES must be at least 2");
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], async_i};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.sync[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/clkloss_counter.sv
module clkloss_counter #(
    parameter int unsigned THRESH = clkloss_pkg::DEF_THRESH,
    localparam int unsigned CNT_W = clkloss_pkg::cnt_width(THRESH)
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_next_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i || restart_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o      = st_q.cnt;
    assign sat_next_o = (st_d.cnt == LIMIT);
endmodule

// File: rtl/clkloss_monitor.sv
module clkloss_monitor #(
    parameter int unsigned THRESH      = clkloss_pkg::DEF_THRESH,
    parameter int unsigned SYNC_STAGES = clkloss_pkg::DEF_SYNC_STAGES
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic ref_div_i,
    input  logic ref_raw_i,
    input  logic scan_en_i,
    input  logic det_en_i,
    output logic loss_o
);
    localparam int unsigned CNT_W = clkloss_pkg::cnt_width(THRESH);

    logic             div_rise;
    logic             raw_rise;
    logic             active;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    logic             sat_next;

    typedef struct packed {
        logic loss;
    } state_t;

    state_t st_d, st_q;

    clkloss_sync_edge #(.STAGES(SYNC_STAGES)) u_div_edge (
        .clk_i   (osc_clk),
        .rst_n   (rst_n),
        .async_i (ref_div_i),
        .rise_o  (div_rise)
    );

    clkloss_sync_edge #(.STAGES(SYNC_STAGES)) u_raw_edge (
        .clk_i   (osc_clk),
        .rst_n   (rst_n),
        .async_i (ref_raw_i),
        .rise_o  (raw_rise)
    );

    assign active  = det_en_i & ~scan_en_i;
    assign restart = div_rise | raw_rise;

    clkloss_counter #(.THRESH(THRESH)) u_cnt (
        .clk_i      (osc_clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .restart_i  (restart),
        .cnt_o      (cnt),
        .sat_next_o (sat_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.loss = active & ~restart & sat_next;
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign loss_o = st_q.loss;
endmodule

// File: rtl/clkloss_monitor_chk.sv
module clkloss_monitor_chk #(
    parameter int unsigned THRESH = clkloss_pkg::DEF_THRESH,
    localparam int unsigned CNT_W = clkloss_pkg::cnt_width(THRESH)
) (
    input logic             clk_i,
    input logic             rst_n,
    input logic             scan_en_i,
    input logic             det_en_i,
    input logic             loss_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             div_rise_i,
    input logic             raw_rise_i
);
    // R7: the counter never runs past the threshold
    a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_n)
        cnt_i <= CNT_W'(THRESH));

    // R2: a detected divided-reference rise restarts the count
    a_r2_div_restart: assert property (@(posedge clk_i) disable iff (!rst_n)
        div_rise_i |=> (cnt_i == '0));

    // R5: a detected raw-reference rise clears the flag
    a_r5_raw_clears: assert property (@(posedge clk_i) disable iff (!rst_n)
        raw_rise_i |=> !loss_i);

    // R6: suppression forces the flag low and the count to zero
    a_r6_suppressed: assert property (@(posedge clk_i) disable iff (!rst_n)
        (scan_en_i || !det_en_i) |=> (!loss_i && cnt_i == '0));

    // R4: the flag is only high while the counter sits at the threshold
    a_r4_flag_at_limit: assert property (@(posedge clk_i) disable iff (!rst_n)
        loss_i |-> (cnt_i == CNT_W'(THRESH)));

    // R4: the flag rises only after a cycle one below the threshold
    a_r4_rise_after_count: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(loss_i) |-> ($past(cnt_i) == CNT_W'(THRESH - 1)));
endmodule

bind clkloss_monitor clkloss_monitor_chk #(.THRESH(THRESH)) u_chk (
    .clk_i      (osc_clk),
    .rst_n      (rst_n),
    .scan_en_i  (scan_en_i),
    .det_en_i   (det_en_i),
    .loss_i     (loss_o),
    .cnt_i      (cnt),
    .div_rise_i (div_rise),
    .raw_rise_i (raw_rise)
);

// File: tb/clkloss_monitor_tb.sv
`timescale 1ns/100ps
module clkloss_monitor_tb;
    localparam int THRESH = 64;
    localparam int WATCHDOG = 150000;

    logic osc_clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div_i = 1'b0;
    logic ref_raw_i = 1'b0;
    logic scan_en_i = 1'b0;
    logic det_en_i = 1'b0;
    logic loss_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string phase = "R1";

    // behavioural model state
    int m_cnt = 0;
    bit m_loss = 1'b0;
    bit dh[3];
    bit rh[3];

    always #2.5 osc_clk = ~osc_clk;

    clkloss_monitor #(.THRESH(THRESH)) u_dut (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .ref_div_i (ref_div_i),
        .ref_raw_i (ref_raw_i),
        .scan_en_i (scan_en_i),
        .det_en_i  (det_en_i),
        .loss_o    (loss_o)
    );

    // Model: an input level seen on edge n-2 but not n-3 is a rising edge acting on edge n
    always @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_loss = 1'b0;
            for (int i = 0; i < 3; i++) begin
                dh[i] = 1'b0;
                rh[i] = 1'b0;
            end
        end else begin
            bit act;
            bit rs;
            cycles++;
            act = det_en_i && !scan_en_i;
            rs = (dh[1] && !dh[2]) || (rh[1] && !rh[2]);
            if (!act || rs) m_cnt = 0;
            else if (m_cnt < THRESH) m_cnt++;
            m_loss = act && (m_cnt >= THRESH);
            dh[2] = dh[1]; dh[1] = dh[0]; dh[0] = ref_div_i;
            rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = ref_raw_i;
        end
    end

    // Every-cycle comparison against the model
    always @(negedge osc_clk) begin
        if (rst_n) begin
            tests++;
            if (loss_o !== m_loss) begin
                fails++;
                $display("FAIL %s model compare at cycle %0d: loss_o=%0b expected %0b",
                         phase, cycles, loss_o, m_loss);
            end
        end
    end

    task automatic check(input string req, input logic exp);
        tests++;
        if (loss_o !== exp) begin
            fails++;
            $display("FAIL %s directed: loss_o=%0b expected %0b", req, loss_o, exp);
        end
    endtask

    task automatic negs(input int n);
        for (int i = 0; i < n; i++) @(negedge osc_clk);
    endtask

    initial begin
        #(WATCHDOG * 5.0);
        fails++;
        $display("FAIL watchdog expired: loss_o=%0b expected completion", loss_o);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        negs(3);
        check("R1", 1'b0);
        rst_n = 1'b1;
        negs(2);
        check("R1", 1'b0);

        // R3: periodic divided reference (period 20) keeps the flag low
        phase = "R3";
        det_en_i = 1'b1;
        for (int k = 0; k < 30; k++) begin
            ref_div_i = 1'b1; negs(10);
            ref_div_i = 1'b0; negs(10);
        end
        check("R3", 1'b0);

        // R3: boundary period of exactly THRESH cycles between rises
        for (int k = 0; k < 8; k++) begin
            ref_div_i = 1'b1; negs(THRESH / 2);
            ref_div_i = 1'b0; negs(THRESH / 2);
            check("R3", 1'b0);
        end

        // R2/R4: single rise then silence; flag timing relative to the rise
        phase = "R4";
        ref_div_i = 1'b1;
        negs(THRESH + 2);
        check("R4", 1'b0);
        negs(1);
        check("R4", 1'b1);

        // R7: saturated counter keeps the flag high
        phase = "R7";
        negs(300);
        check("R7", 1'b1);

        // R8: falling divided reference changes nothing
        phase = "R8";
        ref_div_i = 1'b0;
        negs(6);
        check("R8", 1'b1);

        // R5: raw reference rise clears within its latency
        phase = "R5";
        ref_raw_i = 1'b1;
        negs(2);
        check("R5", 1'b1);
        negs(1);
        check("R5", 1'b0);
        negs(20);
        // R8: raw reference falling does not restart; loss returns on schedule
        phase = "R8";
        ref_raw_i = 1'b0;
        negs(THRESH);
        check("R8", 1'b1);

        // R6: scan mode suppresses on the next edge and restarts counting
        phase = "R6";
        scan_en_i = 1'b1;
        negs(1);
        check("R6", 1'b0);
        negs(100);
        check("R6", 1'b0);
        scan_en_i = 1'b0;
        negs(THRESH - 1);
        check("R6", 1'b0);
        negs(1);
        check("R6", 1'b1);

        // R6: enable low suppresses likewise
        det_en_i = 1'b0;
        negs(1);
        check("R6", 1'b0);
        negs(50);
        check("R6", 1'b0);
        det_en_i = 1'b1;
        negs(THRESH - 1);
        check("R6", 1'b0);
        negs(1);
        check("R6", 1'b1);

        // R2: random mix of references and controls against the model
        phase = "R2";
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) ref_div_i = ~ref_div_i;
            else if (r < 4) ref_raw_i = ~ref_raw_i;
            else if (r == 5) scan_en_i = ~scan_en_i;
            else if (r == 6) det_en_i = 1'b1;
            if (scan_en_i && $urandom_range(0, 9) == 0) scan_en_i = 1'b0;
            negs(1);
        end

        // R1: reset in the middle of a loss condition
        phase = "R1";
        scan_en_i = 1'b0; det_en_i = 1'b1;
        negs(THRESH * 3);
        rst_n = 1'b0;
        negs(1);
        check("R1", 1'b0);
        rst_n = 1'b1;
        negs(2);
        check("R1", 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule